// File: doc/BRIEF.md
# Five-Level Flying-Capacitor Switch State Selector

This block is the per-phase control core of a five-level flying-capacitor inverter leg built from four complementary switch pairs. On each control tick it takes a requested output level from a modulator, one "below target" sign per flying capacitor from comparators, and the polarity of the output current. It then moves the leg to a switch combination that brings the output toward the requested level.

Several combinations produce the same level. The block picks the one that pushes the most flying capacitors toward their targets, which are three quarters, one half and one quarter of the supply. Only one complementary pair may change per transition. A request that is several levels away is therefore reached one level per tick.

Per-channel overcurrent flags are latched. Any latched flag turns all eight gates off until reset.

Top module: `fcs_state_selector`

## Requirements
- R1: After reset the leg is at state index 0 (all lower devices on, `gate_hi`=0000, `gate_lo`=1111), `level_now` is 0 and `ovc_latched` is zero.
- R2: With no latched fault, `gate_hi[k]` equals bit k of `state_idx` (state index = switching state number minus 1), and `gate_lo` is the bitwise complement of `gate_hi`. `level_now` is the number of upper devices on: 0..4 stand for -1, -0.5, 0, +0.5 and +1.
- R3: The state changes only at a clock edge where `tick` is 1.
- R4: When the requested level equals `level_now`, the state holds.
- R5: When the requested level differs, a tick moves the level exactly one step toward it, and exactly one switch pair changes.
- R6: A `level_req` value above 4 is treated as 4.
- R7: Each candidate is scored by how many capacitors it moves toward target. Capacitor k lies between pair k and pair k+1. `cap_low[k]`=1 means it is below target and needs charge; 0 means it needs discharge. With `cur_pos`=1, capacitor k charges when upper k+1 is on and upper k is off, and discharges in the opposite case. The highest score wins.
- R8: Among candidates with equal scores, the lowest state number wins.
- R9: With `cur_pos`=0 the charge and discharge effects of every capacitor are swapped.
- R10: Any `ovc_flag` bit set at an edge is ORed into the matching `ovc_latched` bit, and the bit stays set until reset. While any latched bit is set, all eight gate outputs are 0 and the state holds.
- R11: A fault flag that arrives in the same cycle as a tick keeps the state from advancing at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick | input | 1 | Control tick; enables one state update |
| level_req | input | 3 | Requested level 0..4 (-1 .. +1); values above 4 are clamped |
| cap_low | input | 3 | Per capacitor: 1 = below target |
| cur_pos | input | 1 | 1 = positive output current |
| ovc_flag | input | 8 | Overcurrent flags: bits 3:0 upper devices, bits 7:4 lower devices |
| gate_hi | output | 4 | Upper device gates, one per pair |
| gate_lo | output | 4 | Lower device gates, one per pair |
| state_idx | output | 4 | Present switching state number minus 1 |
| level_now | output | 3 | Present output level 0..4 |
| ovc_latched | output | 8 | Latched overcurrent flags |

## Verification
A state step and a fault capture can fall on the same edge. The bench provokes this by raising a flag together with a tick that requests a new level. It then judges the result by a held `state_idx`, all gates off, and only the flagged channel latched. Later ticks and a second flag show that the hold persists and that the flags accumulate. The selection itself is swept over many combinations of request, capacitor signs and current polarity, against a model that scores candidates arithmetically.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

  // Effect of one candidate on one capacitor: 1 when it moves the
  // capacitor toward its target.
  function automatic logic cap_toward(input logic hi_on, input logic lo_on,
                                      input logic cur_pos, input logic need_chg);
    logic chg, dis;
    chg = hi_on & ~lo_on;
    dis = lo_on & ~hi_on;
    if (!cur_pos) begin
      chg = lo_on & ~hi_on;
      dis = hi_on & ~lo_on;
    end
    return need_chg ? chg : dis;
  endfunction

endpackage

// File: rtl/fcs_cand_score.sv
module fcs_cand_score #(
  parameter int NP = 4,
  localparam int NC = NP - 1,
  localparam int SW = $clog2(NC + 1)
) (
  input  logic [NP-1:0]         cur_code,
  input  logic                  dir_up,
  input  logic [NC-1:0]         cap_low,
  input  logic                  cur_pos,
  output logic [NP-1:0]         cand_ok,
  output logic [NP-1:0][NP-1:0] cand_code,
  output logic [NP-1:0][SW-1:0] cand_score
);
  import fcs_pkg::*;

  for (genvar j = 0; j < NP; j++) begin : g_cand
    always_comb begin
      logic [NP-1:0] c;
      logic [SW-1:0] s;
      c = cur_code ^ (NP'(1) << j);
      s = '0;
      for (int k = 0; k < NC; k++) begin
        if (cap_toward(c[k+1], c[k], cur_pos, cap_low[k])) s = s + SW'(1);
      end
      cand_code[j]  = c;
      cand_score[j] = s;
      cand_ok[j]    = dir_up ? ~cur_code[j] : cur_code[j];
    end
  end

endmodule

// File: rtl/fcs_pick.sv
module fcs_pick #(
  parameter int NP = 4,
  parameter int SW = 2
) (
  input  logic [NP-1:0]         cand_ok,
  input  logic [NP-1:0][NP-1:0] cand_code,
  input  logic [NP-1:0][SW-1:0] cand_score,
  output logic [NP-1:0]         pick_code,
  output logic                  pick_ok
);
  always_comb begin
    logic [SW-1:0] best;
    pick_ok   = 1'b0;
    pick_code = '0;
    best      = '0;
    for (int j = 0; j < NP; j++) begin
      if (cand_ok[j]) begin
        if (!pick_ok || cand_score[j] > best ||
            (cand_score[j] == best && cand_code[j] < pick_code)) begin
          pick_ok   = 1'b1;
          pick_code = cand_code[j];
          best      = cand_score[j];
        end
      end
    end
  end
endmodule

// File: rtl/fcs_fault_latch.sv
module fcs_fault_latch #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] flag_in,
  output logic [NCH-1:0] flag_q,
  output logic           any_q
);
  logic [NCH-1:0] flag_d;

  always_comb flag_d = flag_q | flag_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign any_q = |flag_q;

  // R10: a raised flag is captured at the next edge
  p_capture_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_in != '0) |=> ((flag_q & $past(flag_in)) == $past(flag_in)));

  // R10: captured flags never clear before reset
  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q != '0) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

endmodule

// File: rtl/fcs_state_selector.sv
module fcs_state_selector #(
  parameter int NP = 4,
  localparam int NC  = NP - 1,
  localparam int LW  = $clog2(NP + 1),
  localparam int SW  = $clog2(NC + 1),
  localparam int NCH = 2 * NP
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic [LW-1:0]  level_req,
  input  logic [NC-1:0]  cap_low,
  input  logic           cur_pos,
  input  logic [NCH-1:0] ovc_flag,
  output logic [NP-1:0]  gate_hi,
  output logic [NP-1:0]  gate_lo,
  output logic [NP-1:0]  state_idx,
  output logic [LW-1:0]  level_now,
  output logic [NCH-1:0] ovc_latched
);
  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_pipe;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  logic [NP-1:0] state_q, state_d;
  logic [LW-1:0] req_c;
  logic          dir_up, step_en, fault_any;

  logic [NP-1:0]         cand_ok;
  logic [NP-1:0][NP-1:0] cand_code;
  logic [NP-1:0][SW-1:0] cand_score;
  logic [NP-1:0]         pick_code;
  logic                  pick_ok;

  always_comb begin
    level_now = '0;
    for (int k = 0; k < NP; k++) level_now = level_now + LW'(state_q[k]);
  end

  always_comb req_c = (level_req > LW'(NP)) ? LW'(NP) : level_req;
  always_comb dir_up = (req_c > level_now);

  fcs_cand_score #(.NP(NP)) u_score (
    .cur_code  (state_q),
    .dir_up    (dir_up),
    .cap_low   (cap_low),
    .cur_pos   (cur_pos),
    .cand_ok   (cand_ok),
    .cand_code (cand_code),
    .cand_score(cand_score)
  );

  fcs_pick #(.NP(NP), .SW(SW)) u_pick (
    .cand_ok   (cand_ok),
    .cand_code (cand_code),
    .cand_score(cand_score),
    .pick_code (pick_code),
    .pick_ok   (pick_ok)
  );

  fcs_fault_latch #(.NCH(NCH)) u_fault (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .flag_in(ovc_flag),
    .flag_q (ovc_latched),
    .any_q  (fault_any)
  );

  always_comb begin
    step_en = tick & ~fault_any & ~(|ovc_flag) & (req_c != level_now) & pick_ok;
    state_d = state_q;
    if (step_en) state_d = pick_code;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) state_q <= '0;
    else          state_q <= state_d;
  end

  assign state_idx = state_q;
  assign gate_hi   = fault_any ? '0 : state_q;
  assign gate_lo   = fault_any ? '0 : ~state_q;

  // R5: any state change flips exactly one pair
  p_one_pair_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    (state_q != $past(state_q)) |-> ($countones(state_q ^ $past(state_q)) == 1));

  // R3: no tick, no change
  p_hold_no_tick_r3: assert property (@(posedge clk) disable iff (!rst_s_n)
    !tick |=> $stable(state_q));

  // R2: healthy gates are complementary
  p_complement_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    !fault_any |-> (gate_hi == ~gate_lo));

  // R10: latched fault forces all gates off
  p_fault_off_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
    fault_any |-> (gate_hi == '0 && gate_lo == '0));

  // R11: a flag arriving with a tick blocks the step
  p_collide_r11: assert property (@(posedge clk) disable iff (!rst_s_n)
    (tick && ovc_flag != '0) |=> $stable(state_q));

endmodule

// File: tb/fcs_state_selector_tb_top.sv
module fcs_state_selector_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick;
  logic [2:0] level_req;
  logic [2:0] cap_low;
  logic       cur_pos;
  logic [7:0] ovc_flag;
  logic [3:0] gate_hi, gate_lo, state_idx;
  logic [2:0] level_now;
  logic [7:0] ovc_latched;

  int checks = 0;
  int fails  = 0;
  logic [3:0] exp_code;

  always #5 clk = ~clk;

  fcs_state_selector dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .level_req(level_req),
    .cap_low(cap_low), .cur_pos(cur_pos), .ovc_flag(ovc_flag),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .state_idx(state_idx),
    .level_now(level_now), .ovc_latched(ovc_latched)
  );

  function automatic int ones4(input logic [3:0] v);
    return int'(v[0]) + int'(v[1]) + int'(v[2]) + int'(v[3]);
  endfunction

  function automatic logic [3:0] ref_next(input logic [3:0] code, input int req,
                                          input logic [2:0] low, input logic cp,
                                          input logic tk);
    int lvl, rq, best, s;
    logic [3:0] bc, c;
    logic hi, lo, ch, ds, tmp;
    lvl = ones4(code);
    rq  = (req > 4) ? 4 : req;
    if (!tk || rq == lvl) return code;
    best = -1; bc = code;
    for (int j = 0; j < 4; j++) begin
      if ((rq > lvl) ? !code[j] : code[j]) begin
        c = code ^ (4'(1) << j);
        s = 0;
        for (int k = 0; k < 3; k++) begin
          hi = c[k+1]; lo = c[k];
          ch = hi & !lo; ds = lo & !hi;
          if (!cp) begin tmp = ch; ch = ds; ds = tmp; end
          if (low[k] ? ch : ds) s++;
        end
        if (s > best || (s == best && c < bc)) begin best = s; bc = c; end
      end
    end
    return bc;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic tk, input int req, input logic [2:0] low,
                      input logic cp, input logic [7:0] fl);
    @(negedge clk);
    tick = tk; level_req = 3'(req); cap_low = low; cur_pos = cp; ovc_flag = fl;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tick = 0; level_req = 0; cap_low = 0; cur_pos = 1; ovc_flag = 0;
    #1;
    chk("R1 state", 32'(state_idx), 0);
    chk("R1 gate_hi", 32'(gate_hi), 0);
    chk("R1 gate_lo", 32'(gate_lo), 32'hF);
    chk("R1 level", 32'(level_now), 0);
    chk("R1 flags", 32'(ovc_latched), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    exp_code = 4'd0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick = 0; level_req = 0; cap_low = 0; cur_pos = 1; ovc_flag = 0;
    do_reset();

    // R8: level 0 -> 1, all caps above target, positive current: tie of 1,2,4 -> code 1
    step(1, 1, 3'b000, 1, 0);
    chk("R8 tie lowest", 32'(state_idx), 1);
    do_reset();
    // R9: same request with negative current -> code 2
    step(1, 1, 3'b000, 0, 0);
    chk("R9 inverted current", 32'(state_idx), 2);
    do_reset();
    // R5: request +1 from -1 climbs one level per tick
    for (int t = 1; t <= 4; t++) begin
      step(1, 4, 3'b101, 1, 0);
      chk("R5 one level step", 32'(level_now), 32'(t));
    end
    // R6: request 7 at level 4 holds
    step(1, 7, 3'b010, 0, 0);
    chk("R6 clamp", 32'(state_idx), 32'hF);
    exp_code = 4'hF;

    // sweep
    for (int p = 0; p < 3; p++) begin
      for (int i = 0; i < 128; i++) begin
        int req;
        logic [2:0] low;
        logic cp, tk;
        logic [3:0] nx;
        string tag;
        req = (i * 5 + p * 3 + (i >> 3)) % 8;
        low = 3'((i * 3 + p + (i >> 4)) % 8);
        cp  = 1'(((i >> 2) ^ p) & 1);
        tk  = (i % 7) != 3;
        nx  = ref_next(exp_code, req, low, cp, tk);
        if (!tk) tag = "R3 no tick";
        else if (((req > 4) ? 4 : req) == ones4(exp_code)) tag = (req > 4) ? "R6 clamp hold" : "R4 hold";
        else tag = cp ? "R7 best score" : "R9 neg current";
        step(tk, req, low, cp, 0);
        exp_code = nx;
        chk(tag, 32'(state_idx), 32'(exp_code));
        chk("R2 gates", {24'd0, gate_lo, gate_hi}, {24'd0, ~exp_code, exp_code});
        chk("R2 level", 32'(level_now), 32'(ones4(exp_code)));
      end
    end

    // R11: fault flag together with a tick that would move the state
    begin
      int rq;
      rq = (ones4(exp_code) == 4) ? 0 : 4;
      step(1, rq, 3'b011, 1, 8'h20);
      chk("R11 held", 32'(state_idx), 32'(exp_code));
      chk("R10 latched", 32'(ovc_latched), 32'h20);
      chk("R10 gates off", {24'd0, gate_lo, gate_hi}, 0);
      step(1, rq, 3'b011, 1, 8'h00);
      chk("R10 state frozen", 32'(state_idx), 32'(exp_code));
      chk("R10 sticky", 32'(ovc_latched), 32'h20);
      step(0, rq, 3'b011, 1, 8'h01);
      chk("R10 accumulate", 32'(ovc_latched), 32'h21);
      chk("R10 gates still off", {24'd0, gate_lo, gate_hi}, 0);
    end
    do_reset();
    step(1, 1, 3'b111, 1, 0);
    chk("R7 after reset", 32'(state_idx), 32'(ref_next(4'd0, 1, 3'b111, 1, 1)));

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule